// File: doc/BRIEF.md
# Pushbutton Reset Pulse Generator

This block turns a mechanical pushbutton into a clean system reset. The button input is active low and is expected to bounce. It first passes through a two-flop synchronizer, then through a debouncer that takes a new level only once that level has held steady for a set time. A recognized press drives reset active straight away. Reset stays active for as long as the button is held down.

When the debounced button is released, a timed interval begins. Reset stays active until the interval ends. A length-select input picks the interval: a short one (95 ms by default) or a long one (190 ms by default). The select is captured at the moment of release. The clock frequency and all three times are parameters.

The block gives an active-high reset, its active-low complement, and a request line. The request can be ORed with the reset from a supply monitor.

Top module: `pbr_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with the button up, `rst_out` is 0, `rst_out_n` is 1 and `rst_req` is 0.
- R2: A low level on `btn_n` that lasts fewer than DB cycles never asserts reset. DB = CLK_KHZ*DEBOUNCE_MS.
- R3: A clean press asserts `rst_out` on the (DB+3)th rising clock edge after `btn_n` falls. Any bounce that settles low counts from its last falling transition.
- R4: Reset stays asserted for the whole time the debounced button is held low, however long that is.
- R5: With `long_sel`=0 at release, `rst_out` deasserts on the (DB+S+3)th rising edge after the final rise of `btn_n`. S = CLK_KHZ*SHORT_MS.
- R6: With `long_sel`=1 at release, the same count uses L = CLK_KHZ*LONG_MS in place of S.
- R7: `long_sel` is sampled only when the debounced release is recognized. Changes to it during the timed interval have no effect on the interval's length.
- R8: A debounced press during the timed interval returns the block to the held state. Reset stays asserted without a gap, and a fresh full interval starts on the next release.
- R9: `rst_out_n` is always the exact complement of `rst_out`, and `rst_req` always equals `rst_out`. All three are driven from registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| btn_n | input | 1 | Raw pushbutton, low when pressed, asynchronous |
| long_sel | input | 1 | 1 selects the long post-release interval, 0 the short one |
| rst_out | output | 1 | Active-high reset |
| rst_out_n | output | 1 | Active-low reset |
| rst_req | output | 1 | Reset request for merging with other reset sources |

## Verification
The assertions assume that `rst_n` is held low across the first clock edges, so that no history before reset is ever consulted. They also assume that `btn_n` and `long_sel` move only between clock edges. The bench keeps within this by changing its inputs only on the falling clock edge and by asserting reset from time zero. It reads the outputs on the falling edge as well. The debouncer assertions further assume that the synchronizer output is the only path by which the button reaches the debounced level. The bench therefore drives the button only through `btn_n`, including its bounce and glitch patterns.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
    typedef enum logic [1:0] {
        PB_IDLE  = 2'd0,
        PB_HOLD  = 2'd1,
        PB_TIMED = 2'd2
    } pb_state_e;
endpackage

// File: rtl/pbr_sync.sv
module pbr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = din;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: 1'b1, s2: 1'b1};
        else        r_q <= r_d;
    end

    assign dout = r_q.s2;
endmodule

// File: rtl/pbr_debounce.sv
module pbr_debounce #(
    parameter int unsigned DB_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    localparam int unsigned CW = $clog2(DB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (din == r_q.lvl) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.lvl = din;
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{lvl: 1'b1, cnt: '0};
        else        r_q <= r_d;
    end

    assign level = r_q.lvl;

    // R2: the settled level moves only toward a differing synchronized input
    a_r2_level_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.lvl != $past(r_q.lvl)) |-> ($past(din) != $past(r_q.lvl)));

    // R2: the settled level never moves before the count window is full
    a_r2_window_full: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.lvl != $past(r_q.lvl)) |-> ($past(r_q.cnt) == LAST));
endmodule

// File: rtl/pbr_pulse.sv
module pbr_pulse
    import pbr_pkg::*;
#(
    parameter int unsigned SHORT_CYC = 95000,
    parameter int unsigned LONG_CYC  = 190000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    input  logic long_sel,
    output logic act_hi,
    output logic act_lo
);
    localparam int unsigned CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_L = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_L  = CW'(LONG_CYC);

    typedef struct packed {
        pb_state_e     st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic          hi;
        logic          lo;
    } pul_t;

    pul_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PB_IDLE: begin
                if (pressed) r_d.st = PB_HOLD;
            end
            PB_HOLD: begin
                if (!pressed) begin
                    r_d.st  = PB_TIMED;
                    r_d.cnt = '0;
                    r_d.len = long_sel ? LONG_L : SHORT_L;
                end
            end
            PB_TIMED: begin
                if (pressed) begin
                    r_d.st = PB_HOLD;
                end else if (r_q.cnt == r_q.len - 1'b1) begin
                    r_d.st = PB_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = PB_IDLE;
        endcase
        r_d.hi = (r_d.st != PB_IDLE);
        r_d.lo = (r_d.st == PB_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PB_IDLE, cnt: '0, len: SHORT_L, hi: 1'b0, lo: 1'b1};
        else        r_q <= r_d;
    end

    assign act_hi = r_q.hi;
    assign act_lo = r_q.lo;

    // R3: reset rises only after a recognized press
    a_r3_rise_on_press: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.hi) |-> $past(pressed));

    // R4: the held state always drives reset
    a_r4_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PB_HOLD) |-> r_q.hi);

    // R4: reset does not fall while the button is held
    a_r4_no_drop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hi && pressed) |=> r_q.hi);

    // R5: the interval counter stays below the latched length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PB_TIMED) |-> (r_q.cnt < r_q.len));

    // R7: the latched length is stable through the timed interval
    a_r7_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PB_TIMED && $past(r_q.st) == PB_TIMED) |-> $stable(r_q.len));

    // R8: a press during the interval goes back to holding
    a_r8_repress: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PB_TIMED && pressed) |=> (r_q.st == PB_HOLD && r_q.hi));

    // R9: the two polarities are exact complements
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.hi != r_q.lo));
endmodule

// File: rtl/pbr_top.sv
module pbr_top #(
    parameter int unsigned CLK_KHZ     = 1000,
    parameter int unsigned DEBOUNCE_MS = 10,
    parameter int unsigned SHORT_MS    = 95,
    parameter int unsigned LONG_MS     = 190
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic long_sel,
    output logic rst_out,
    output logic rst_out_n,
    output logic rst_req
);
    localparam int unsigned DB_CYC    = CLK_KHZ * DEBOUNCE_MS;
    localparam int unsigned SHORT_CYC = CLK_KHZ * SHORT_MS;
    localparam int unsigned LONG_CYC  = CLK_KHZ * LONG_MS;

    logic btn_sync;
    logic btn_level;
    logic act_hi;
    logic act_lo;

    pbr_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (btn_n),
        .dout  (btn_sync)
    );

    pbr_debounce #(.DB_CYC(DB_CYC)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (btn_sync),
        .level (btn_level)
    );

    pbr_pulse #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .pressed  (!btn_level),
        .long_sel (long_sel),
        .act_hi   (act_hi),
        .act_lo   (act_lo)
    );

    assign rst_out   = act_hi;
    assign rst_out_n = act_lo;
    assign rst_req   = act_hi;

    // R9: the request line mirrors the active-high reset
    a_r9_req_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req == rst_out);
endmodule

// File: tb/test_pbr_top.sv
module test_pbr_top;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ = 4;
    localparam int DB  = KHZ * 10;
    localparam int SH  = KHZ * 95;
    localparam int LG  = KHZ * 190;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic long_sel = 1'b0;
    logic rst_out, rst_out_n, rst_req;
    int   n_chk = 0;
    int   n_err = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbr_top #(.CLK_KHZ(KHZ), .DEBOUNCE_MS(10), .SHORT_MS(95), .LONG_MS(190)) i_pbr_top (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .long_sel(long_sel),
        .rst_out(rst_out), .rst_out_n(rst_out_n), .rst_req(rst_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts rising edges until rst_out reaches the target value
    task automatic measure(input logic target, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rst_out == target) break;
        end
    endtask

    task automatic bounce(input int times, input logic final_lvl);
        for (int i = 0; i < times; i++) begin
            btn_n = ~final_lvl; cycles(3);
            btn_n = final_lvl;  cycles(2);
        end
        btn_n = ~final_lvl; cycles(2);
        btn_n = final_lvl;
    endtask

    task automatic t_reset();
        cycles(2);
        check("R1 rst_out in reset", rst_out, 0);
        check("R1 rst_out_n in reset", rst_out_n, 1);
        rst_n = 1'b1;
        cycles(5);
        check("R1 rst_out after reset", rst_out, 0);
        check("R1 rst_req after reset", rst_req, 0);
    endtask

    task automatic t_glitch();
        int hits = 0;
        btn_n = 1'b0; cycles(DB - 2);
        btn_n = 1'b1;
        for (int i = 0; i < 3 * DB; i++) begin
            @(negedge clk);
            if (rst_out) hits++;
        end
        check("R2 short low ignored", hits, 0);
    endtask

    task automatic t_cycle(input logic sel, input logic flip_sel, input int len, input string tag);
        int n, drops;
        long_sel = sel;
        bounce(4, 1'b0);
        measure(1'b1, 4 * DB, n);
        check("R3 press latency", n, DB + 3);
        check("R9 complement on press", rst_out_n, 0);
        drops = 0;
        for (int i = 0; i < 5 * DB; i++) begin
            @(negedge clk);
            if (!rst_out) drops++;
        end
        check("R4 held stays asserted", drops, 0);
        bounce(3, 1'b1);
        if (flip_sel) begin
            cycles(DB + 20);
            long_sel = ~sel;
            measure(1'b0, len + 4 * DB, n);
            n = n + DB + 20;
        end else begin
            measure(1'b0, len + 4 * DB, n);
        end
        check(tag, n, DB + len + 3);
        check("R9 complement after", rst_out_n, 1);
        check("R9 request mirrors", rst_req, 0);
        cycles(10);
    endtask

    task automatic t_repress();
        int n, drops;
        long_sel = 1'b0;
        btn_n = 1'b0;
        measure(1'b1, 4 * DB, n);
        cycles(20);
        btn_n = 1'b1;
        cycles(DB + 100);
        btn_n = 1'b0;
        drops = 0;
        for (int i = 0; i < 2 * DB; i++) begin
            @(negedge clk);
            if (!rst_out) drops++;
        end
        check("R8 no gap on re-press", drops, 0);
        btn_n = 1'b1;
        measure(1'b0, SH + 4 * DB, n);
        check("R8 full interval after re-release", n, DB + SH + 3);
    endtask

    initial begin
        t_reset();
        t_glitch();
        t_cycle(1'b0, 1'b0, SH, "R5 short interval");
        t_cycle(1'b1, 1'b0, LG, "R6 long interval");
        t_cycle(1'b1, 1'b1, LG, "R7 select change ignored");
        t_cycle(1'b0, 1'b1, SH, "R7 select change ignored short");
        t_repress();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule